// File: doc/BRIEF.md
# Vertical Laplacian Sharpener

This block sharpens a stream of 8-bit grey pixels across scan lines. Pixels arrive one per accepted clock, column by column along each line. The block holds the two most recent full lines in a single circular store. For every new pixel it therefore has three vertically aligned samples: the pixel two lines back (a), the pixel one line back (n, the centre), and the incoming pixel (b).

The block computes n + k·(2n − (a + b)). It first adds the two outer samples and subtracts that sum from twice the centre. It then scales the difference by an unsigned coefficient k with 4 integer and 4 fractional bits, rounds the product to the nearest integer, adds the centre and clamps the result to 0..255. The coefficient is sampled with each pixel and travels alongside it, so k may change from one pixel to the next. An input qualifier marks accepted pixels, and an output qualifier marks results. No result is produced until two whole lines have been stored.

The design has three register stages. A pixel accepted at clock edge E gives its result, with the output qualifier high, right after edge E+2. The line length is a parameter with a default of 5120 columns.

Top module: `vlap_sharpen`

## Requirements
- R1: For each result, out_pix = clamp(n + round(d·k/16)), where d = 2n − a − b. Here a, n and b are the pixels in the same column two lines back, one line back and on the current line. k is coef_k read as unsigned 4.4 fixed point. round(x/16) is floor((x + 8)/16), so halves round upward.
- R2: A result below 0 comes out as 0, and a result above 255 comes out as 255.
- R3: After reset, the first 2·LINE_LEN accepted pixels produce no result. Every accepted pixel after those produces exactly one result, and results come out in input order.
- R4: The result of a pixel accepted at clock edge E appears on out_pix, with out_valid high, just after edge E+2. out_valid is high for one cycle per result.
- R5: Cycles with in_valid low advance neither the column position nor the line count. Idle gaps therefore leave every later result unchanged.
- R6: With rst_n low at a clock edge (synchronous, active low), out_valid and out_pix become 0 and the line fill count restarts from zero.
- R7: With coef_k = 0 the result equals the centre pixel, which is the input from one line earlier in the same column.
- R8: The column position wraps after LINE_LEN accepted pixels. Column alignment between the three lines holds over any number of lines.
- R9: While out_valid is low, out_pix keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel on in_pix is accepted at this edge |
| in_pix | input | PIX_W | Incoming pixel (next-line sample b) |
| coef_k | input | K_INT+K_FRAC | Unsigned fixed-point sharpening coefficient, travels with the pixel |
| out_valid | output | 1 | out_pix holds a new result |
| out_pix | output | PIX_W | Sharpened, clamped pixel |

## Verification
The bench uses a short line so that the circular store wraps many times. A store that drifts by a column would mix neighbouring columns and give wrong values on the wrapped lines. Alternating 0/255 rows with the largest coefficient push the result far outside the pixel range, which exposes a missing clamp or a wrapped sum. Odd second differences with a half-valued coefficient land exactly on rounding halves, so a truncating or wrongly signed shift shows up as an off-by-one. Idle gaps and a reset between two streams test the fill gate. A design that counts idle cycles, or that keeps its fill state across reset, emits results too early or emits the wrong number of them.

// File: rtl/vlap_sharpen.sv
module vlap_sharpen #(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 5120,
  parameter int K_INT    = 4,
  parameter int K_FRAC   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [PIX_W-1:0]         in_pix,
  input  logic [K_INT+K_FRAC-1:0]  coef_k,
  output logic                     out_valid,
  output logic [PIX_W-1:0]         out_pix
);
  localparam int AW  = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam int K_W = K_INT + K_FRAC;
  localparam int D_W = PIX_W + 3;
  localparam int P_W = D_W + K_W + 1;
  localparam logic signed [P_W-1:0] HALF = P_W'(1) << (K_FRAC - 1);
  localparam logic signed [P_W-1:0] TOP  = P_W'((1 << PIX_W) - 1);

  logic [2*PIX_W-1:0] store [LINE_LEN];
  logic [AW-1:0]      col;
  logic [1:0]         lines;

  wire [2*PIX_W-1:0] word     = store[col];
  wire               last_col = (col == AW'(LINE_LEN - 1));
  wire               full     = (lines == 2'd2);

  always_ff @(posedge clk)
    if (in_valid) store[col] <= {in_pix, word[2*PIX_W-1:PIX_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col   <= '0;
      lines <= '0;
    end else if (in_valid) begin
      col <= last_col ? '0 : col + 1'b1;
      if (last_col && !full) lines <= lines + 1'b1;
    end
  end

  logic             v1;
  logic [PIX_W-1:0] a1, n1, b1;
  logic [K_W-1:0]   k1;

  always_ff @(posedge clk) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid && full;
    a1 <= word[PIX_W-1:0];
    n1 <= word[2*PIX_W-1:PIX_W];
    b1 <= in_pix;
    k1 <= coef_k;
  end

  wire [PIX_W:0]          outer = {1'b0, a1} + {1'b0, b1};
  wire signed [D_W-1:0]   diff  = $signed({2'b00, n1, 1'b0}) - $signed({2'b00, outer});

  logic                  v2;
  logic signed [D_W-1:0] d2;
  logic [PIX_W-1:0]      n2;
  logic [K_W-1:0]        k2;

  always_ff @(posedge clk) begin
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;
    d2 <= diff;
    n2 <= n1;
    k2 <= k1;
  end

  wire signed [P_W-1:0] prod = $signed({{(K_W+1){d2[D_W-1]}}, d2}) * $signed({{D_W{1'b0}}, 1'b0, k2});
  wire signed [P_W-1:0] rnd  = (prod + HALF) >>> K_FRAC;
  wire signed [P_W-1:0] sum  = rnd + $signed({{(P_W-PIX_W){1'b0}}, n2});
  wire [PIX_W-1:0]      clip = (sum < 0) ? '0 : (sum > TOP) ? {PIX_W{1'b1}} : sum[PIX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= v2;
      if (v2) out_pix <= clip;
    end
  end
endmodule

module vlap_sharpen_chk #(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 5120
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);
  localparam int CW = $clog2(2*LINE_LEN + 1) + 1;

  logic [CW-1:0] seen;
  wire emit = in_valid && (seen == CW'(2*LINE_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && seen != CW'(2*LINE_LEN)) seen <= seen + 1'b1;
  end

  assert_fill_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(emit, 3));

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_pix));

  assert_reset_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_pix == '0));
endmodule

bind vlap_sharpen vlap_sharpen_chk #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/vlap_sharpen_tb.sv
module vlap_sharpen_tb;
  localparam int L = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_pix = '0;
  logic [7:0] coef_k = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  vlap_sharpen #(.PIX_W(8), .LINE_LEN(L), .K_INT(4), .K_FRAC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .coef_k(coef_k), .out_valid(out_valid), .out_pix(out_pix)
  );

  always #4 clk = ~clk;

  typedef struct { int val; int cyc; string tag; } item_t;
  item_t exp_q[$];
  int    hist[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  int    last_out = 0;
  bit    gap_before = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic send(int pix, int k);
    item_t it;
    int p, a, n, d, r, y;
    @(negedge clk);
    in_valid = 1'b1;
    in_pix   = pix[7:0];
    coef_k   = k[7:0];
    p = hist.size();
    if (p >= 2*L) begin
      a = hist[p-2*L];
      n = hist[p-L];
      d = 2*n - a - pix;
      r = (d*k + 8) >>> 4;
      y = n + r;
      if (k == 0)             it.tag = "R7";
      else if (y < 0 || y > 255) it.tag = "R2";
      else if (gap_before)    it.tag = "R5";
      else if (p >= 4*L)      it.tag = "R8";
      else                    it.tag = "R1";
      it.val = (y < 0) ? 0 : (y > 255) ? 255 : y;
      it.cyc = cyc + 3;
      exp_q.push_back(it);
    end
    hist.push_back(pix);
    gap_before = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    if (n > 0) gap_before = 1;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(out_pix == it.val[7:0], it.tag, out_pix, it.val);
          check(cyc == it.cyc, "R4", cyc, it.cyc);
          last_out = out_pix;
        end
      end else begin
        check(out_pix == last_out[7:0], "R9", out_pix, last_out);
      end
    end
  end

  initial begin
    #(8 * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int kl[7];
    kl = '{16, 8, 24, 3, 40, 16, 9};
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R6", out_valid, 0);
    check(out_pix == 8'd0, "R6", out_pix, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int ln = 0; ln < 6; ln++)
      for (int c = 0; c < L; c++) begin
        send(((ln*37 + c*53) ^ (c << 4)) & 255, kl[ln]);
        if (((ln*L + c) % 5) == 4) idle(1 + (c % 2));
      end
    for (int c = 0; c < 3; c++) send((c*91 + 17) & 255, 12);
    idle(6);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);

    @(negedge clk);
    rst_n = 1'b0;
    hist.delete();
    last_out = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R6", out_valid, 0);
    check(out_pix == 8'd0, "R6", out_pix, 0);
    @(negedge clk);
    rst_n = 1'b1;

    begin
      int k2[7];
      k2 = '{0, 255, 8, 255, 0, 128, 17};
      for (int ln = 0; ln < 7; ln++)
        for (int c = 0; c < L; c++) begin
          if (ln % 2 == 0) send(((c + ln) % 2) ? 255 : 0, k2[ln]);
          else             send((c*29 + ln*7 + 1) & 255, k2[ln]);
          if (c == 3) idle(2);
        end
    end
    idle(6);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    check(hist.size() == 7*L, "R3", hist.size(), 7*L);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule